// File: doc/BRIEF.md
# Resource-Aware Work-Group Dispatcher

This block takes one launch descriptor at a time from the host side and hands the work groups it describes to an array of compute units, one group per cycle at most. The descriptor gives the number of groups and what each group needs: a thread count, a shared-memory byte count and a per-thread register count. The total register need of a group is the thread count times the per-thread register count. The dispatcher keeps a free-resource ledger for every unit, covering threads, shared memory, registers and group slots. A unit can take a group only when every ledger entry covers the need. Among units that can take one, selection rotates round-robin, so that threads spread evenly over the array.

Each issue debits the chosen unit's ledger. Each completion report credits the named unit with the running grid's demands. Groups are never dropped or reordered: when no unit can take the next group, issue waits for completions. By default the array has 30 units, laid out as 10 clusters of 3. A descriptor that no single unit could ever hold is refused with an error pulse, so that it cannot deadlock the block.

Top module: `grid_block_dispatcher`

## Requirements
- R1: When idle, a `launch_valid` with an admissible descriptor makes `launch_accept` pulse for one cycle after the sampling edge. `busy` rises in that same cycle and clears `grid_done`.
- R2: A descriptor is refused when any of these holds: zero groups, zero threads, threads above the per-unit thread capacity, shared memory above the per-unit shared-memory capacity, or threads × registers-per-thread above the per-unit register capacity. A refused descriptor gives a one-cycle `launch_error` pulse, with no accept, no `busy` and no issue. A demand exactly equal to a capacity is admitted.
- R3: A group is issued only to a unit whose free threads, free shared memory and free registers each cover the group's demand, and which has at least one free group slot.
- R4: The unit search starts at the index after the last unit that received a group (unit 0 after reset). It wraps from the highest index to 0 and skips units that cannot take the group.
- R5: `issue_valid` pulses at most once per cycle. `issue_index` is 0 for a grid's first group and rises by 1 with each issue.
- R6: While no unit can take the next group, nothing is issued. Issue resumes once completions have freed enough resources.
- R7: A `done_valid` report credits unit `done_unit` with one group's demands. When an issue and a completion hit the same unit in the same cycle, both take effect.
- R8: Once every group has been issued and reported complete, `busy` falls and `grid_done` rises in the cycle after the last completion is sampled. `grid_done` stays high until the next accept.
- R9: A `launch_valid` that arrives while `busy` is high is ignored. It gives no accept and no error, and the running grid's issue order is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Launch descriptor present |
| launch_blocks | input | BLK_W | Number of work groups in the grid |
| launch_threads | input | THR_W | Threads per group |
| launch_smem | input | SMEM_W | Shared-memory bytes per group |
| launch_rpt | input | RPT_W | Registers per thread |
| launch_accept | output | 1 | One-cycle pulse: descriptor taken |
| launch_error | output | 1 | One-cycle pulse: descriptor refused |
| issue_valid | output | 1 | A group is issued this cycle |
| issue_unit | output | CU_W | Target compute unit |
| issue_index | output | BLK_W | Sequential group index within the grid |
| done_valid | input | 1 | Completion report present |
| done_unit | input | CU_W | Unit that finished one group |
| busy | output | 1 | A grid is in progress |
| grid_done | output | 1 | The last grid has fully completed |

## Verification
Every result is registered once. Accept, error, `busy` and the issue outputs appear in the cycle after the edge that sampled the stimulus. A completion sampled at an edge affects eligibility from the next edge on, so a freed unit can receive a group no earlier than the cycle after the one in which the completion is seen. The bench's driver predicts, for every edge, what the outputs must show right after that edge and queues that prediction. The monitor pops one entry per cycle, 1 ns after the rising edge, so each comparison lands exactly one register stage behind its stimulus.

// File: rtl/gbd_pkg.sv
package gbd_pkg;

  typedef enum logic {GBD_IDLE, GBD_RUN} gbd_state_e;

  // Total register need of one group.
  function automatic int unsigned reg_need(int unsigned thr, int unsigned rpt);
    return thr * rpt;
  endfunction

  // Descriptor admission: it must fit a single, empty unit.
  function automatic logic desc_ok(int unsigned blocks, int unsigned thr,
                                   int unsigned smem, int unsigned rpt,
                                   int unsigned thr_cap, int unsigned smem_cap,
                                   int unsigned reg_cap);
    return (blocks != 0) && (thr != 0) && (thr <= thr_cap) &&
           (smem <= smem_cap) && (reg_need(thr, rpt) <= reg_cap);
  endfunction

  // Round-robin successor.
  function automatic int unsigned wrap_next(int unsigned i, int unsigned n);
    return (i + 1 >= n) ? 0 : i + 1;
  endfunction

endpackage

// File: rtl/gbd_unit_ledger.sv
module gbd_unit_ledger #(
  parameter int THR_CAP  = 1024,
  parameter int SMEM_CAP = 16384,
  parameter int REG_CAP  = 16384,
  parameter int SLOT_CAP = 8,
  localparam int THR_W  = $clog2(THR_CAP + 1),
  localparam int SMEM_W = $clog2(SMEM_CAP + 1),
  localparam int REG_W  = $clog2(REG_CAP + 1),
  localparam int SLOT_W = $clog2(SLOT_CAP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              give,
  input  logic [THR_W-1:0]  need_thr,
  input  logic [SMEM_W-1:0] need_smem,
  input  logic [REG_W-1:0]  need_reg,
  output logic              eligible
);
  logic [THR_W-1:0]  free_thr;
  logic [SMEM_W-1:0] free_smem;
  logic [REG_W-1:0]  free_reg;
  logic [SLOT_W-1:0] free_slot;

  assign eligible = (free_thr >= need_thr) && (free_smem >= need_smem) &&
                    (free_reg >= need_reg) && (free_slot != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_thr  <= THR_W'(THR_CAP);
      free_smem <= SMEM_W'(SMEM_CAP);
      free_reg  <= REG_W'(REG_CAP);
      free_slot <= SLOT_W'(SLOT_CAP);
    end else begin
      free_thr  <= free_thr  + (give ? need_thr  : '0) - (take ? need_thr  : '0);
      free_smem <= free_smem + (give ? need_smem : '0) - (take ? need_smem : '0);
      free_reg  <= free_reg  + (give ? need_reg  : '0) - (take ? need_reg  : '0);
      free_slot <= free_slot + SLOT_W'(give) - SLOT_W'(take);
    end
  end
endmodule

// File: rtl/gbd_rr_pick.sv
module gbd_rr_pick #(
  parameter int N = 30,
  parameter int W = 5
) (
  input  logic [N-1:0] elig,
  input  logic [W-1:0] ptr,
  output logic         found,
  output logic [W-1:0] idx,
  output logic [N-1:0] grant_oh
);
  int c;
  always_comb begin
    found    = 1'b0;
    idx      = '0;
    grant_oh = '0;
    c        = 0;
    for (int k = 0; k < N; k++) begin
      c = int'(ptr) + k;
      if (c >= N) c = c - N;
      if (!found && elig[c]) begin
        found = 1'b1;
        idx   = W'(c);
      end
    end
    if (found) grant_oh[idx] = 1'b1;
  end
endmodule

// File: rtl/grid_block_dispatcher.sv
module grid_block_dispatcher
  import gbd_pkg::*;
#(
  parameter int CLUSTER_CNT       = 10,
  parameter int UNITS_PER_CLUSTER = 3,
  parameter int BLK_W             = 16,
  parameter int THR_CAP           = 1024,
  parameter int SMEM_CAP          = 16384,
  parameter int REG_CAP           = 16384,
  parameter int SLOT_CAP          = 8,
  parameter int RPT_W             = 8,
  localparam int NUM_CU = CLUSTER_CNT * UNITS_PER_CLUSTER,
  localparam int CU_W   = (NUM_CU > 1) ? $clog2(NUM_CU) : 1,
  localparam int THR_W  = $clog2(THR_CAP + 1),
  localparam int SMEM_W = $clog2(SMEM_CAP + 1),
  localparam int REG_W  = $clog2(REG_CAP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_valid,
  input  logic [BLK_W-1:0]  launch_blocks,
  input  logic [THR_W-1:0]  launch_threads,
  input  logic [SMEM_W-1:0] launch_smem,
  input  logic [RPT_W-1:0]  launch_rpt,
  output logic              launch_accept,
  output logic              launch_error,
  output logic              issue_valid,
  output logic [CU_W-1:0]   issue_unit,
  output logic [BLK_W-1:0]  issue_index,
  input  logic              done_valid,
  input  logic [CU_W-1:0]   done_unit,
  output logic              busy,
  output logic              grid_done
);
  gbd_state_e        st_q;
  logic [BLK_W-1:0]  rem_q, out_q, idx_q;
  logic [CU_W-1:0]   ptr_q;
  logic [THR_W-1:0]  dem_thr_q;
  logic [SMEM_W-1:0] dem_smem_q;
  logic [REG_W-1:0]  dem_reg_q;

  // Named internal events, also observed by the checker.
  logic [NUM_CU-1:0] elig_vec, pick_oh, take_vec, give_vec;
  logic              pick_found, issue_fire, done_hit, launch_take, desc_good, finish;
  logic [CU_W-1:0]   pick_idx;
  logic [BLK_W-1:0]  rem_nx, out_nx;

  assign desc_good   = desc_ok(32'(launch_blocks), 32'(launch_threads), 32'(launch_smem),
                               32'(launch_rpt), THR_CAP, SMEM_CAP, REG_CAP);
  assign launch_take = (st_q == GBD_IDLE) && launch_valid;
  assign issue_fire  = (st_q == GBD_RUN) && (rem_q != '0) && pick_found;
  assign done_hit    = (st_q == GBD_RUN) && done_valid;
  assign rem_nx      = rem_q - BLK_W'(issue_fire);
  assign out_nx      = out_q + BLK_W'(issue_fire) - BLK_W'(done_hit);
  assign finish      = (st_q == GBD_RUN) && (rem_nx == '0) && (out_nx == '0);

  gbd_rr_pick #(.N(NUM_CU), .W(CU_W)) u_pick (
    .elig(elig_vec), .ptr(ptr_q), .found(pick_found), .idx(pick_idx), .grant_oh(pick_oh)
  );

  for (genvar g = 0; g < NUM_CU; g++) begin : g_unit
    assign take_vec[g] = issue_fire && pick_oh[g];
    assign give_vec[g] = done_hit && (done_unit == CU_W'(g));
    gbd_unit_ledger #(
      .THR_CAP(THR_CAP), .SMEM_CAP(SMEM_CAP), .REG_CAP(REG_CAP), .SLOT_CAP(SLOT_CAP)
    ) u_ledger (
      .clk(clk), .rst_n(rst_n), .take(take_vec[g]), .give(give_vec[g]),
      .need_thr(dem_thr_q), .need_smem(dem_smem_q), .need_reg(dem_reg_q),
      .eligible(elig_vec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q          <= GBD_IDLE;
      rem_q         <= '0;
      out_q         <= '0;
      idx_q         <= '0;
      ptr_q         <= '0;
      dem_thr_q     <= '0;
      dem_smem_q    <= '0;
      dem_reg_q     <= '0;
      launch_accept <= 1'b0;
      launch_error  <= 1'b0;
      issue_valid   <= 1'b0;
      issue_unit    <= '0;
      issue_index   <= '0;
      grid_done     <= 1'b0;
    end else begin
      launch_accept <= launch_take && desc_good;
      launch_error  <= launch_take && !desc_good;
      issue_valid   <= issue_fire;
      if (issue_fire) begin
        issue_unit  <= pick_idx;
        issue_index <= idx_q;
        idx_q       <= idx_q + 1'b1;
        ptr_q       <= CU_W'(wrap_next(32'(pick_idx), NUM_CU));
      end
      if (launch_take && desc_good) begin
        st_q       <= GBD_RUN;
        rem_q      <= launch_blocks;
        out_q      <= '0;
        idx_q      <= '0;
        dem_thr_q  <= launch_threads;
        dem_smem_q <= launch_smem;
        dem_reg_q  <= REG_W'(reg_need(32'(launch_threads), 32'(launch_rpt)));
        grid_done  <= 1'b0;
      end else if (st_q == GBD_RUN) begin
        rem_q <= rem_nx;
        out_q <= out_nx;
        if (finish) begin
          st_q      <= GBD_IDLE;
          grid_done <= 1'b1;
        end
      end
    end
  end

  assign busy = (st_q == GBD_RUN);
endmodule

// File: rtl/gbd_checker.sv
module gbd_checker #(
  parameter int NUM_CU = 30,
  parameter int CU_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              issue_valid,
  input logic              launch_accept,
  input logic              launch_error,
  input logic              grid_done,
  input logic [NUM_CU-1:0] elig_vec,
  input logic [NUM_CU-1:0] pick_oh,
  input logic              pick_found,
  input logic [CU_W-1:0]   pick_idx,
  input logic              issue_fire
);
  p_pick_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pick_found |-> elig_vec[pick_idx]);
  p_single_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_oh) && (pick_found == ($countones(pick_oh) == 1)));
  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_vec == '0) |-> !issue_fire);
  p_issue_in_grid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> busy);
  p_accept_error_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch_accept && launch_error));
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    launch_accept |-> busy);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grid_done |-> !busy);
  p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !launch_accept);
endmodule

bind grid_block_dispatcher gbd_checker #(.NUM_CU(NUM_CU), .CU_W(CU_W)) u_gbd_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy), .issue_valid(issue_valid),
  .launch_accept(launch_accept), .launch_error(launch_error), .grid_done(grid_done),
  .elig_vec(elig_vec), .pick_oh(pick_oh), .pick_found(pick_found),
  .pick_idx(pick_idx), .issue_fire(issue_fire)
);

// File: tb/grid_block_dispatcher_bench.sv
`timescale 1ns/1ps
module grid_block_dispatcher_bench;
  localparam int NC = 4, TC = 256, SC = 1024, RC = 2048, SLC = 2;
  localparam int BLK_W = 16, RPT_W = 8, CU_W = 2;
  localparam int THR_W = $clog2(TC + 1), SMEM_W = $clog2(SC + 1);

  logic clk = 0, rst_n = 0;
  logic launch_valid = 0, done_valid = 0;
  logic [BLK_W-1:0] launch_blocks = 0;
  logic [THR_W-1:0] launch_threads = 0;
  logic [SMEM_W-1:0] launch_smem = 0;
  logic [RPT_W-1:0] launch_rpt = 0;
  logic [CU_W-1:0] done_unit = 0;
  logic launch_accept, launch_error, issue_valid, busy, grid_done;
  logic [CU_W-1:0] issue_unit;
  logic [BLK_W-1:0] issue_index;

  always #2 clk = ~clk;

  grid_block_dispatcher #(
    .CLUSTER_CNT(2), .UNITS_PER_CLUSTER(2), .BLK_W(BLK_W), .THR_CAP(TC),
    .SMEM_CAP(SC), .REG_CAP(RC), .SLOT_CAP(SLC), .RPT_W(RPT_W)
  ) u_grid_block_dispatcher (.*);

  typedef struct {bit valid; int unit; int idx; bit acc; bit err; bit busy; bit gd;} exp_t;
  exp_t exq[$];
  exp_t mon_e;
  int outq[$];
  int checks = 0, fails = 0;
  string cur_tag = "R1";

  // Independent model of the requirements.
  bit m_run = 0, m_gd = 0;
  int m_rem, m_out, m_idx, m_ptr = 0;
  int f_thr[NC], f_sm[NC], f_rg[NC], f_sl[NC];
  int d_thr, d_sm, d_rg;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: apply inputs at negedge, predict the post-edge outputs, queue them.
  task automatic step(bit lv, int bl, int th, int sm, int rp, bit dv, int du);
    exp_t e;
    @(negedge clk);
    launch_valid = lv; launch_blocks = BLK_W'(bl); launch_threads = THR_W'(th);
    launch_smem = SMEM_W'(sm); launch_rpt = RPT_W'(rp);
    done_valid = dv; done_unit = CU_W'(du);
    e = '{valid:0, unit:0, idx:0, acc:0, err:0, busy:0, gd:0};
    if (!m_run) begin
      if (lv) begin
        if (bl > 0 && th > 0 && th <= TC && sm <= SC && th * rp <= RC) begin
          e.acc = 1; m_run = 1; m_rem = bl; m_out = 0; m_idx = 0; m_gd = 0;
          d_thr = th; d_sm = sm; d_rg = th * rp;
        end else e.err = 1;
      end
    end else begin
      if (m_rem > 0) begin
        for (int k = 0; k < NC; k++) begin
          int u;
          u = (m_ptr + k) % NC;
          if (!e.valid && f_thr[u] >= d_thr && f_sm[u] >= d_sm && f_rg[u] >= d_rg && f_sl[u] > 0) begin
            e.valid = 1; e.unit = u; e.idx = m_idx;
          end
        end
        if (e.valid) begin
          f_thr[e.unit] -= d_thr; f_sm[e.unit] -= d_sm; f_rg[e.unit] -= d_rg; f_sl[e.unit] -= 1;
          m_idx++; m_rem--; m_out++; m_ptr = (e.unit + 1) % NC; outq.push_back(e.unit);
        end
      end
      if (dv) begin
        f_thr[du] += d_thr; f_sm[du] += d_sm; f_rg[du] += d_rg; f_sl[du] += 1; m_out--;
      end
      if (m_rem == 0 && m_out == 0) begin m_run = 0; m_gd = 1; end
    end
    e.busy = m_run; e.gd = m_gd;
    exq.push_back(e);
  endtask

  // Monitor: one queued prediction per cycle, 1 ns after the rising edge.
  always @(posedge clk) begin
    #1;
    if (exq.size() > 0) begin
      mon_e = exq.pop_front();
      chk(launch_accept == mon_e.acc, "R1", "launch_accept", launch_accept, mon_e.acc);
      chk(launch_error == mon_e.err, "R2", "launch_error", launch_error, mon_e.err);
      chk(busy == mon_e.busy, "R1 R8", "busy", busy, mon_e.busy);
      chk(grid_done == mon_e.gd, "R8", "grid_done", grid_done, mon_e.gd);
      chk(issue_valid == mon_e.valid, {"R5 R6 ", cur_tag}, "issue_valid", issue_valid, mon_e.valid);
      if (mon_e.valid && issue_valid) begin
        chk(int'(issue_unit) == mon_e.unit, {"R3 R4 ", cur_tag}, "issue_unit", issue_unit, mon_e.unit);
        chk(int'(issue_index) == mon_e.idx, {"R5 ", cur_tag}, "issue_index", issue_index, mon_e.idx);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic run_grid(int bl, int th, int sm, int rp, int period, bit poke);
    step(1, bl, th, sm, rp, 0, 0);
    for (int cyc = 1; m_run && cyc < 4000; cyc++) begin
      bit dv; int du;
      dv = 0; du = 0;
      if (outq.size() > 0 && cyc % period == 0) begin dv = 1; du = outq.pop_front(); end
      step(poke && (cyc % 4 == 2), 5, 64, 64, 1, dv, du);
    end
    idle(2);
  endtask

  initial begin
    for (int u = 0; u < NC; u++) begin f_thr[u] = TC; f_sm[u] = SC; f_rg[u] = RC; f_sl[u] = SLC; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1;
    chk(!busy && !grid_done && !issue_valid && !launch_accept && !launch_error,
        "R1", "reset outputs quiet", busy | grid_done | issue_valid, 0);
    // R2: refusals, including each capacity axis
    cur_tag = "R2";
    step(1, 4, 300, 10, 1, 0, 0); idle(1);
    step(1, 4, 64, 10, 40, 0, 0); idle(1);
    step(1, 0, 64, 10, 1, 0, 0); idle(1);
    step(1, 4, 64, 2000, 1, 0, 0); idle(1);
    step(1, 4, 0, 10, 1, 0, 0); idle(1);
    // R1 R4 R5 R8: simple grid, fast completions
    cur_tag = "R4";
    run_grid(6, 128, 256, 4, 1, 0);
    // R6: one group fills a unit's threads, slow completions force stalls
    cur_tag = "R6";
    run_grid(9, 256, 100, 2, 3, 0);
    // R7 R9: issue and completion collide; launches while busy ignored
    cur_tag = "R7 R9";
    run_grid(12, 64, 512, 8, 1, 1);
    // R2 boundary: every demand exactly at capacity is admitted
    cur_tag = "R2";
    run_grid(3, 256, 1024, 8, 2, 0);
    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all R) actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule